// File: doc/BRIEF.md
# Upset-Gated Windowed Accumulator

This block integrates a stream of signed samples, such as spectral power bins, over fixed time windows. Each window is summed in a short intermediate register. When the window ends, its total is held back until a programmable guard period has also run out. Only after that does the block decide what to do with it. The guard exists because an upset detector, such as a configuration scrubber, reports a fault some time after the fault actually happened. Any data collected shortly before a report must therefore be treated as suspect.

The block has two modes. In drop mode, a window total is added to a wide long-term sum only if the upset-detect input stayed low for the whole window and the whole guard. A window that fails this test is discarded, and a saturating counter records the loss. In tag mode, no window is discarded. Every window total is emitted as a one-cycle record carrying a clean/suspect bit, so it can be stored and filtered later. While one window waits out its guard, the next window is already accumulating, so the sample stream never stalls.

Top module: `upset_gated_accum`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after any cycle with `clr_i` high, `total_o` and `drop_cnt_o` are 0 and `rec_vld_o` is 0. `clr_i` discards any partial or pending window, and the next window starts with the cycle after the clear.
- R2: A window spans `win_len_i` clock cycles, and a value of 0 acts as 1. Only cycles with `smp_vld_i` high add their sample to the window sum.
- R3: In drop mode (`mode_i`=0), a clean window's sum is added to `total_o`. The new total becomes visible `guard_len_i`+2 cycles after the window's last cycle, and not earlier.
- R4: In drop mode, a window in which `upset_i` was high in any cycle is discarded. `total_o` is left unchanged and `drop_cnt_o` increases by one.
- R5: An upset in any of the `guard_len_i`+1 cycles that follow a window's last cycle also condemns that window. An upset in any later cycle does not.
- R6: Samples arriving while the previous window is still in its guard are accumulated into the next window and none are lost, provided `guard_len_i` < `win_len_i`.
- R7: In tag mode (`mode_i`=1), each window produces a one-cycle `rec_vld_o` pulse at the same time a drop-mode commit would take effect. The pulse carries the window sum on `rec_sum_o`, and `rec_ok_o` is 1 for a clean window and 0 for a suspect one. `total_o` and `drop_cnt_o` do not change. `rec_vld_o` is never raised in drop mode.
- R8: `drop_cnt_o` never decreases except on clear, and it saturates at 2^DROP_W-1.
- R9: Samples are two's-complement. Negative values are sign-extended into the window sum and into `total_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of sums, pending window and counter |
| mode_i | input | 1 | 0 = drop suspect windows, 1 = tag every window |
| win_len_i | input | WIN_LEN_W | Window length in cycles |
| guard_len_i | input | GUARD_W | Guard length in cycles after the window |
| smp_vld_i | input | 1 | Sample valid |
| smp_data_i | input | SAMPLE_W | Signed sample value |
| upset_i | input | 1 | Upset-detected pulse |
| total_o | output | SAMPLE_W+WIN_LEN_W+COMMIT_W | Long-term signed sum of committed windows |
| rec_vld_o | output | 1 | Record strobe (tag mode) |
| rec_sum_o | output | SAMPLE_W+WIN_LEN_W | Signed window sum of the record |
| rec_ok_o | output | 1 | Record clean flag |
| drop_cnt_o | output | DROP_W | Saturating count of discarded windows |

## Verification
The bench builds the block with 8-bit samples, a 5-bit window length, a 4-bit guard length, 6 commit bits and a 3-bit drop counter. It runs with windows of 8 cycles and a guard of 3 cycles. These short windows place an upset in the last window cycle, in the last guard cycle and in the first cycle after the guard, all within a few dozen cycles. The 3-bit counter saturates after only seven condemned windows, so its ceiling can be reached and held. A one-cycle window with a zero guard exercises the shortest legal pipeline.

// File: rtl/uga_pkg.sv
package uga_pkg;
    typedef enum logic {
        MODE_DROP = 1'b0,
        MODE_TAG  = 1'b1
    } uga_mode_e;
endpackage

// File: rtl/uga_window.sv
// Collects one window: cycle counter, running sum and upset flag.
module uga_window #(
    parameter int SAMPLE_W = 16,
    parameter int LEN_W    = 12,
    parameter int SUM_W    = 28
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clr_i,
    input  logic [LEN_W-1:0]    win_len_i,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic                upset_i,
    output logic                close_o,
    output logic [SUM_W-1:0]    close_sum_o,
    output logic                close_bad_o
);
    localparam int EXT_W = SUM_W - SAMPLE_W;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        logic             bad;
    } win_t;

    win_t st_d, st_q;
    logic [SUM_W-1:0] add_w, sum_inc_w;
    logic             last_w, bad_now_w;

    always_comb begin
        add_w     = smp_vld_i ? {{EXT_W{smp_data_i[SAMPLE_W-1]}}, smp_data_i} : '0;
        sum_inc_w = st_q.sum + add_w;
        bad_now_w = st_q.bad | upset_i;
        // a zero length compares as one cycle
        last_w    = ({1'b0, st_q.cnt} + (LEN_W+1)'(1)) >= {1'b0, win_len_i};

        close_o     = last_w && !clr_i;
        close_sum_o = sum_inc_w;
        close_bad_o = bad_now_w;

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (last_w) begin
            st_d = '0;
        end else begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
            st_d.sum = sum_inc_w;
            st_d.bad = bad_now_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/uga_guard.sv
// Holds a closed window until its guard period has run out.
module uga_guard #(
    parameter int SUM_W   = 28,
    parameter int GUARD_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_i,
    input  logic [GUARD_W-1:0] guard_len_i,
    input  logic               upset_i,
    input  logic               close_i,
    input  logic [SUM_W-1:0]   close_sum_i,
    input  logic               close_bad_i,
    output logic               pend_o,
    output logic               decide_o,
    output logic [SUM_W-1:0]   dec_sum_o,
    output logic               dec_bad_o
);
    typedef struct packed {
        logic               pend;
        logic [GUARD_W-1:0] gcnt;
        logic [SUM_W-1:0]   sum;
        logic               bad;
    } grd_t;

    grd_t st_d, st_q;

    always_comb begin
        pend_o    = st_q.pend;
        decide_o  = st_q.pend && (st_q.gcnt == '0) && !clr_i;
        dec_sum_o = st_q.sum;
        dec_bad_o = st_q.bad | upset_i;

        st_d = st_q;
        if (st_q.pend) begin
            if (st_q.gcnt == '0) begin
                st_d.pend = 1'b0;
            end else begin
                st_d.gcnt = st_q.gcnt - GUARD_W'(1);
                st_d.bad  = st_q.bad | upset_i;
            end
        end
        if (close_i) begin
            st_d.pend = 1'b1;
            st_d.gcnt = guard_len_i;
            st_d.sum  = close_sum_i;
            st_d.bad  = close_bad_i;
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/uga_commit.sv
// Applies the decision: fold into the total, drop and count, or emit a record.
module uga_commit #(
    parameter int SUM_W  = 28,
    parameter int TOT_W  = 44,
    parameter int DROP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  uga_pkg::uga_mode_e mode_i,
    input  logic              decide_i,
    input  logic [SUM_W-1:0]  dec_sum_i,
    input  logic              dec_bad_i,
    output logic [TOT_W-1:0]  total_o,
    output logic              rec_vld_o,
    output logic [SUM_W-1:0]  rec_sum_o,
    output logic              rec_ok_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    import uga_pkg::*;

    localparam int                EXT_W    = TOT_W - SUM_W;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    typedef struct packed {
        logic [TOT_W-1:0]  total;
        logic              rvld;
        logic [SUM_W-1:0]  rsum;
        logic              rok;
        logic [DROP_W-1:0] drops;
    } cmt_t;

    cmt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (decide_i) begin
            if (mode_i == MODE_TAG) begin
                st_d.rvld = 1'b1;
                st_d.rsum = dec_sum_i;
                st_d.rok  = !dec_bad_i;
            end else if (!dec_bad_i) begin
                st_d.total = st_q.total + {{EXT_W{dec_sum_i[SUM_W-1]}}, dec_sum_i};
            end else if (st_q.drops != DROP_MAX) begin
                st_d.drops = st_q.drops + DROP_W'(1);
            end
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign total_o    = st_q.total;
    assign rec_vld_o  = st_q.rvld;
    assign rec_sum_o  = st_q.rsum;
    assign rec_ok_o   = st_q.rok;
    assign drop_cnt_o = st_q.drops;
endmodule

// File: rtl/upset_gated_accum.sv
module upset_gated_accum #(
    parameter int SAMPLE_W  = 16,
    parameter int WIN_LEN_W = 12,
    parameter int GUARD_W   = 16,
    parameter int COMMIT_W  = 16,
    parameter int DROP_W    = 8
) (
    input  logic                                           clk_i,
    input  logic                                           rst_ni,
    input  logic                                           clr_i,
    input  logic                                           mode_i,
    input  logic [WIN_LEN_W-1:0]                           win_len_i,
    input  logic [GUARD_W-1:0]                             guard_len_i,
    input  logic                                           smp_vld_i,
    input  logic signed [SAMPLE_W-1:0]                     smp_data_i,
    input  logic                                           upset_i,
    output logic signed [SAMPLE_W+WIN_LEN_W+COMMIT_W-1:0]  total_o,
    output logic                                           rec_vld_o,
    output logic signed [SAMPLE_W+WIN_LEN_W-1:0]           rec_sum_o,
    output logic                                           rec_ok_o,
    output logic [DROP_W-1:0]                              drop_cnt_o
);
    localparam int SUM_W = SAMPLE_W + WIN_LEN_W;
    localparam int TOT_W = SUM_W + COMMIT_W;

    logic             close_w, close_bad_w, pend_w, decide_w, dec_bad_w;
    logic [SUM_W-1:0] close_sum_w, dec_sum_w, rec_sum_w;
    logic [TOT_W-1:0] total_w;
    uga_pkg::uga_mode_e mode_w;

    assign mode_w = uga_pkg::uga_mode_e'(mode_i);

    uga_window #(.SAMPLE_W(SAMPLE_W), .LEN_W(WIN_LEN_W), .SUM_W(SUM_W)) u_window (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .win_len_i(win_len_i),
        .smp_vld_i(smp_vld_i), .smp_data_i(smp_data_i), .upset_i(upset_i),
        .close_o(close_w), .close_sum_o(close_sum_w), .close_bad_o(close_bad_w)
    );

    uga_guard #(.SUM_W(SUM_W), .GUARD_W(GUARD_W)) u_guard (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .guard_len_i(guard_len_i),
        .upset_i(upset_i), .close_i(close_w), .close_sum_i(close_sum_w),
        .close_bad_i(close_bad_w), .pend_o(pend_w), .decide_o(decide_w),
        .dec_sum_o(dec_sum_w), .dec_bad_o(dec_bad_w)
    );

    uga_commit #(.SUM_W(SUM_W), .TOT_W(TOT_W), .DROP_W(DROP_W)) u_commit (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .mode_i(mode_w),
        .decide_i(decide_w), .dec_sum_i(dec_sum_w), .dec_bad_i(dec_bad_w),
        .total_o(total_w), .rec_vld_o(rec_vld_o), .rec_sum_o(rec_sum_w),
        .rec_ok_o(rec_ok_o), .drop_cnt_o(drop_cnt_o)
    );

    assign total_o   = total_w;
    assign rec_sum_o = rec_sum_w;
endmodule

// File: rtl/uga_checker.sv
module uga_checker #(
    parameter int TOT_W  = 44,
    parameter int DROP_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              clr_i,
    input logic              mode_i,
    input logic              close_i,
    input logic              pend_i,
    input logic              decide_i,
    input logic [TOT_W-1:0]  total_i,
    input logic              rec_vld_i,
    input logic [DROP_W-1:0] drop_cnt_i
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    // R1
    clear_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (total_i == '0 && drop_cnt_i == '0 && !rec_vld_i));

    // R3
    total_only_on_decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !decide_i) |=> $stable(total_i));

    // R7
    tag_keeps_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && mode_i) |=> $stable(total_i));

    // R7
    record_only_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(decide_i && mode_i) |=> !rec_vld_i);

    // R8
    drop_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (drop_cnt_i >= $past(drop_cnt_i)));

    // R8
    drop_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && drop_cnt_i == DROP_MAX) |=> (drop_cnt_i == DROP_MAX));

    // R6
    no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        close_i |-> (!pend_i || decide_i));
endmodule

bind upset_gated_accum uga_checker #(.TOT_W(TOT_W), .DROP_W(DROP_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .mode_i(mode_i),
    .close_i(close_w), .pend_i(pend_w), .decide_i(decide_w),
    .total_i(total_w), .rec_vld_i(rec_vld_o), .drop_cnt_i(drop_cnt_o)
);

// File: tb/upset_gated_accum_bench.sv
`timescale 1ns/1ps
module upset_gated_accum_bench;
    localparam int SW = 8, LW = 5, GW = 4, CW = 6, DW = 3;
    localparam int SUMW = SW + LW, TOTW = SUMW + CW;
    localparam int W = 8, G = 3;

    // vector table: mode, sample base, upset cycle (-1 none), expected clean
    localparam int NV = 9;
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1};
    localparam int V_BASE [NV] = '{5, -7, 3, 3, 4, 4, 2, -3, 6};
    localparam int V_UPS  [NV] = '{-1, -1, 0, W-1, W+G, W+G+1, -1, 2, W+1};
    localparam int V_OK   [NV] = '{1, 1, 0, 0, 0, 1, 1, 0, 0};

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, mode = 1'b0;
    logic [LW-1:0] win_len = LW'(W);
    logic [GW-1:0] guard_len = GW'(G);
    logic smp_vld = 1'b0, upset = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic signed [TOTW-1:0] total;
    logic rec_vld, rec_ok;
    logic signed [SUMW-1:0] rec_sum;
    logic [DW-1:0] drop_cnt;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    upset_gated_accum #(.SAMPLE_W(SW), .WIN_LEN_W(LW), .GUARD_W(GW),
                        .COMMIT_W(CW), .DROP_W(DW)) u_upset_gated_accum (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .mode_i(mode),
        .win_len_i(win_len), .guard_len_i(guard_len), .smp_vld_i(smp_vld),
        .smp_data_i(smp_data), .upset_i(upset), .total_o(total),
        .rec_vld_o(rec_vld), .rec_sum_o(rec_sum), .rec_ok_o(rec_ok),
        .drop_cnt_o(drop_cnt)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int wsum(input int base);
        int s = 0;
        for (int t = 0; t < W; t++) if (t % 3 != 2) s += base + t;
        return s;
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; smp_vld = 1'b0; upset = 1'b0;
    endtask

    task automatic run_vec(input int m, input int base, input int ups, input int ok);
        int s = wsum(base);
        mode = m[0];
        do_clear();
        for (int t = 0; t <= W + G + 1; t++) begin
            @(negedge clk);
            clr = 1'b0;
            if (t == W + G) begin
                chk(int'(total), 0, "R3 total before guard end");
                chk(int'(rec_vld), 0, "R7 record before guard end");
            end
            if (t == W + G + 1) begin
                if (m == 0) begin
                    chk(int'(total), ok ? s : 0, ok ? "R3/R9 commit" : "R4/R5 discard");
                    chk(int'(drop_cnt), ok ? 0 : 1, "R4 drop count");
                    chk(int'(rec_vld), 0, "R7 no record in drop mode");
                end else begin
                    chk(int'(rec_vld), 1, "R7 record strobe");
                    chk(int'(rec_sum), s, "R7 record sum");
                    chk(int'(rec_ok), ok, "R7 record clean bit");
                    chk(int'(total), 0, "R7 total untouched");
                    chk(int'(drop_cnt), 0, "R7 drop count untouched");
                end
            end
            smp_vld  = (t < W) && (t % 3 != 2);
            smp_data = SW'(base + t);
            upset    = (t == ups);
        end
        @(negedge clk);
        smp_vld = 1'b0; upset = 1'b0;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(total), 0, "R1 reset total");
        chk(int'(drop_cnt), 0, "R1 reset drop count");
        chk(int'(rec_vld), 0, "R1 reset record");
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) run_vec(V_MODE[v], V_BASE[v], V_UPS[v], V_OK[v]);

        // R1: a partial window with an upset is wiped by the clear
        mode = 1'b0;
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            smp_vld = 1'b1; smp_data = 8'sd50; upset = 1'b1;
        end
        run_vec(0, 1, -1, 1);
        chk(int'(total), wsum(1), "R1 clear discards partial window");

        // R6: back-to-back windows, second accumulates during first guard
        mode = 1'b0;
        do_clear();
        for (int t = 0; t <= 2 * W + G + 1; t++) begin
            @(negedge clk);
            clr = 1'b0;
            if (t == W + G + 1) chk(int'(total), wsum(1), "R6 first window");
            if (t == 2 * W + G + 1) chk(int'(total), wsum(1) + wsum(10), "R6 second window");
            if (t < W) begin
                smp_vld = (t % 3 != 2); smp_data = SW'(1 + t);
            end else if (t < 2 * W) begin
                smp_vld = ((t - W) % 3 != 2); smp_data = SW'(10 + t - W);
            end else begin
                smp_vld = 1'b0;
            end
        end

        // R2: zero length acts as one-cycle windows, zero guard
        win_len = '0; guard_len = '0;
        do_clear();
        for (int t = 0; t <= 3; t++) begin
            @(negedge clk);
            clr = 1'b0;
            if (t == 2) chk(int'(total), 5, "R2 one-cycle window first");
            if (t == 3) chk(int'(total), 14, "R2 one-cycle window second");
            smp_vld = (t < 2); smp_data = (t == 0) ? 8'sd5 : 8'sd9;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        win_len = LW'(W); guard_len = GW'(G);

        // R8: drop counter saturates
        mode = 1'b0;
        do_clear();
        for (int t = 0; t < 9 * W + G + 2; t++) begin
            @(negedge clk);
            clr = 1'b0; smp_vld = 1'b1; smp_data = 8'sd1; upset = 1'b1;
        end
        @(negedge clk);
        upset = 1'b0; smp_vld = 1'b0;
        chk(int'(drop_cnt), 7, "R8 drop counter saturated");
        chk(int'(total), 0, "R4 nothing committed under upsets");

        do_clear();
        @(negedge clk);
        clr = 1'b0;
        chk(int'(drop_cnt), 0, "R1 clear resets drop count");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule